// File: doc/BRIEF.md
# Serial ADC Conversion Controller

This block sits on the host side of a 16-bit successive-approximation converter that has a convert strobe and a three-wire serial port. When the user raises a start request, the controller drops the strobe briefly so the converter samples its input. It then raises the strobe and holds it high for a fixed number of system clocks so the conversion can finish. After that it drops the strobe again and runs sixteen serial clocks. During those clocks it captures the result on each rising edge and sends a two-bit multiplexer word on the data-in line. When it is idle the strobe stays high, which lets the converter sleep between samples.

The converter applies a multiplexer word to the conversion after the readout in which the word was sent. For this reason the controller tags every result with the selection that was actually in force for that sample. The serial clock is the system clock divided by an even number that the user supplies, and the divider is never allowed below two. A request that arrives while a frame is running is queued and served as soon as the frame ends.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While reset is asserted and just after it, `adc_conv` is 1, `adc_sck` is 0, `adc_sdi` is 0, and `busy` and `res_valid` are 0.
- R2: While no frame is running (`busy` = 0), `adc_conv` stays at 1.
- R3: In every frame, `adc_conv` is high for exactly CONV_CYC system clocks between the edge that starts the conversion and the falling edge that opens the readout.
- R4: `adc_sck` is high only while `adc_conv` is low.
- R5: Each readout window has exactly DATA_W rising edges of `adc_sck`, never more.
- R6: `adc_sdo` is sampled at each `adc_sck` rising edge. The first sampled bit is the result MSB, and the bits fill `res_data` from bit DATA_W-1 down to bit 0.
- R7: The multiplexer word goes out on `adc_sdi` in this order: first the single-ended flag (1 = measure against ground), then the odd flag. Each bit is stable at its rising edge. After those two bits, `adc_sdi` is 0. `adc_sdi` changes only at an `adc_sck` falling edge or at the readout's `adc_conv` falling edge.
- R8: `res_tag` = {single, odd} is the word sent in the previous readout. After reset it is 2'b10 (channel 0 against ground).
- R9: The result code follows the selection. Single-ended with odd=0 measures channel 0; single-ended with odd=1 measures channel 1. Differential with odd=0 gives channel 0 minus channel 1, and with odd=1 gives channel 1 minus channel 0. Codes are unipolar straight binary, so a zero or negative difference reads 0x0000.
- R10: The serial clock period is E system clocks, high for E/2 of them. If `sck_div` is below 2, E = 2; otherwise E = `sck_div` with bit 0 cleared. `res_valid` rises SAMP_CYC + CONV_CYC + 16·E clocks after the edge that accepts the request.
- R11: A request that arrives while `busy` = 1 is held and served in the clock after the running frame ends. It is never dropped.
- R12: `res_valid` is a single-cycle pulse, once per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| start_req | input | 1 | Request one conversion frame |
| mode_single | input | 1 | 1 = single-ended, 0 = differential |
| chan_odd | input | 1 | Channel / polarity select |
| sck_div | input | DIV_W | Serial clock divider |
| adc_conv | output | 1 | Convert strobe to the converter |
| adc_sck | output | 1 | Serial clock to the converter |
| adc_sdi | output | 1 | Multiplexer word to the converter |
| adc_sdo | input | 1 | Serial result from the converter |
| busy | output | 1 | Frame in progress |
| res_valid | output | 1 | Result strobe |
| res_data | output | DATA_W | Conversion result |
| res_tag | output | 2 | Selection in force for this result |

## Verification
The latency of every frame is fixed by its inputs. `res_valid` is due exactly SAMP_CYC + CONV_CYC + 16·E clocks after the accepting edge, so the bench counts falling clock edges from that edge and requires the pulse on that exact count. Data, tag, edge count and the bits sent are sampled in the same half-cycle. The bench reads the measured SCK high time and the pulse width one clock later, because the high-time counter closes one edge after the final SCK fall. A queued request is due one clock after the first frame ends plus one full latency, and the bench checks it at that count.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   localparam int CFG_W = 2;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SAMP = 2'd1,
      ST_CONV = 2'd2,
      ST_XFER = 2'd3
   } seq_state_t;

   typedef struct packed {
      logic single;
      logic odd;
   } mux_word_t;
endpackage

// File: rtl/adc_sck_gen.sv
module adc_sck_gen #(
   parameter int HW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [HW-1:0] half,
   output logic          sck,
   output logic          rise_now,
   output logic          fall_now
);
   logic [HW-1:0] hc;
   logic          tog;

   // one toggle every 'half' system clocks while running
   assign tog      = run && (hc == half - 1'b1);
   assign rise_now = tog && !sck;
   assign fall_now = tog && sck;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hc  <= '0;
         sck <= 1'b0;
      end else if (!run) begin
         hc  <= '0;
         sck <= 1'b0;
      end else if (tog) begin
         hc  <= '0;
         sck <= ~sck;
      end else begin
         hc  <= hc + 1'b1;
      end
   end
endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq
   import adc_seq_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int SAMP_CYC = 4,
   parameter int CONV_CYC = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic rise_now,
   input  logic fall_now,
   output logic conv,
   output logic busy,
   output logic run_xfer,
   output logic start_p,
   output logic load_p,
   output logic done_p
);
   localparam int TMAX = (CONV_CYC > SAMP_CYC) ? CONV_CYC : SAMP_CYC;
   localparam int TW   = $clog2(TMAX + 1);
   localparam int EW   = $clog2(2 * DATA_W) + 1;
   localparam logic [TW-1:0] SAMP_LAST = TW'(SAMP_CYC - 1);
   localparam logic [TW-1:0] CONV_LAST = TW'(CONV_CYC - 1);
   localparam logic [EW-1:0] EDGE_LAST = EW'(2 * DATA_W - 1);

   seq_state_t    state;
   logic [TW-1:0] tc;
   logic [EW-1:0] ec;
   logic          pend;

   assign busy     = (state != ST_IDLE);
   assign run_xfer = (state == ST_XFER);
   assign start_p  = (state == ST_IDLE) && (req || pend);
   assign load_p   = (state == ST_CONV) && (tc == CONV_LAST);
   assign done_p   = (state == ST_XFER) && fall_now && (ec == EDGE_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= 1'b0;
      end else if (state == ST_IDLE) begin
         pend <= 1'b0;
      end else if (req) begin
         pend <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         tc    <= '0;
         ec    <= '0;
         conv  <= 1'b1;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (start_p) begin
                  state <= ST_SAMP;
                  tc    <= '0;
                  conv  <= 1'b0;
               end
            end
            ST_SAMP: begin
               if (tc == SAMP_LAST) begin
                  state <= ST_CONV;
                  tc    <= '0;
                  conv  <= 1'b1;
               end else begin
                  tc <= tc + 1'b1;
               end
            end
            ST_CONV: begin
               if (load_p) begin
                  state <= ST_XFER;
                  tc    <= '0;
                  ec    <= '0;
                  conv  <= 1'b0;
               end else begin
                  tc <= tc + 1'b1;
               end
            end
            ST_XFER: begin
               if (done_p) begin
                  state <= ST_IDLE;
                  conv  <= 1'b1;
               end else if (rise_now || fall_now) begin
                  ec <= ec + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/adc_shift_io.sv
module adc_shift_io
   import adc_seq_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_p,
   input  logic              rise_now,
   input  logic              fall_now,
   input  logic [CFG_W-1:0]  word,
   input  logic              sdo,
   output logic              sdi,
   output logic [DATA_W-1:0] rdata
);
   logic [CFG_W-1:0] wsh;

   // outgoing word: first bit set up at window open, next at each SCK fall
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wsh <= '0;
         sdi <= 1'b0;
      end else if (load_p) begin
         wsh <= word;
         sdi <= word[CFG_W-1];
      end else if (fall_now) begin
         sdi <= wsh[CFG_W-2];
         wsh <= {wsh[CFG_W-2:0], 1'b0};
      end
   end

   // incoming result, MSB first, sampled as SCK rises
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (rise_now) begin
         rdata <= {rdata[DATA_W-2:0], sdo};
      end
   end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int         DATA_W   = 16,
   parameter int         DIV_W    = 8,
   parameter int         SAMP_CYC = 4,
   parameter int         CONV_CYC = 64,
   parameter logic [1:0] RST_CFG  = 2'b10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_req,
   input  logic              mode_single,
   input  logic              chan_odd,
   input  logic [DIV_W-1:0]  sck_div,
   output logic              adc_conv,
   output logic              adc_sck,
   output logic              adc_sdi,
   input  logic              adc_sdo,
   output logic              busy,
   output logic              res_valid,
   output logic [DATA_W-1:0] res_data,
   output logic [1:0]        res_tag
);
   localparam int HW = DIV_W - 1;

   generate
      if (DATA_W < 2) begin : g_bad_data_w
         $error("DATA_W must be at least 2");
      end
      if (DIV_W < 2) begin : g_bad_div_w
         $error("DIV_W must be at least 2");
      end
      if (SAMP_CYC < 1) begin : g_bad_samp
         $error("SAMP_CYC must be at least 1");
      end
      if (CONV_CYC < 1) begin : g_bad_conv
         $error("CONV_CYC must be at least 1");
      end
      if (CFG_W != 2) begin : g_bad_cfg
         $error("multiplexer word must be two bits");
      end
   endgenerate

   logic            start_p, load_p, done_p, run_xfer;
   logic            rise_now, fall_now;
   logic [HW-1:0]   half_in, half_sel;
   mux_word_t       cfg_sel;
   logic [1:0]      cfg_live;
   logic [DATA_W-1:0] rdata;

   // even divider clamped to 2: half period in system clocks
   assign half_in = (sck_div < DIV_W'(2)) ? HW'(1) : sck_div[DIV_W-1:1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_sel <= HW'(1);
         cfg_sel  <= mux_word_t'(RST_CFG);
      end else if (start_p) begin
         half_sel <= half_in;
         cfg_sel  <= '{single: mode_single, odd: chan_odd};
      end
   end

   adc_frame_seq #(
      .DATA_W   (DATA_W),
      .SAMP_CYC (SAMP_CYC),
      .CONV_CYC (CONV_CYC)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (start_req),
      .rise_now (rise_now),
      .fall_now (fall_now),
      .conv     (adc_conv),
      .busy     (busy),
      .run_xfer (run_xfer),
      .start_p  (start_p),
      .load_p   (load_p),
      .done_p   (done_p)
   );

   adc_sck_gen #(
      .HW (HW)
   ) u_sck (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run_xfer),
      .half     (half_sel),
      .sck      (adc_sck),
      .rise_now (rise_now),
      .fall_now (fall_now)
   );

   adc_shift_io #(
      .DATA_W (DATA_W)
   ) u_io (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_p   (load_p),
      .rise_now (rise_now),
      .fall_now (fall_now),
      .word     (cfg_sel),
      .sdo      (adc_sdo),
      .sdi      (adc_sdi),
      .rdata    (rdata)
   );

   // the word sent now governs the next conversion; tag with the one in force
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_data  <= '0;
         res_tag   <= RST_CFG;
         cfg_live  <= RST_CFG;
      end else begin
         res_valid <= done_p;
         if (done_p) begin
            res_data <= rdata;
            res_tag  <= cfg_live;
            cfg_live <= cfg_sel;
         end
      end
   end
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
   parameter int DATA_W   = 16,
   parameter int CONV_CYC = 64
) (
   input logic clk,
   input logic rst_n,
   input logic adc_conv,
   input logic adc_sck,
   input logic adc_sdi,
   input logic busy,
   input logic res_valid
);
   localparam int HW = $clog2(CONV_CYC + 1);
   localparam int RW = $clog2(DATA_W + 1) + 1;
   localparam logic [HW-1:0] HI_SAT = HW'(CONV_CYC);
   localparam logic [RW-1:0] RMAX   = RW'(DATA_W);

   logic [HW-1:0] hi_run, hi_at_fall;
   logic [RW-1:0] rise_cnt;
   logic          conv_q, sck_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_run     <= '0;
         hi_at_fall <= '0;
         rise_cnt   <= '0;
         conv_q     <= 1'b1;
         sck_q      <= 1'b0;
      end else begin
         conv_q <= adc_conv;
         sck_q  <= adc_sck;
         if (adc_conv) hi_run <= (hi_run == HI_SAT) ? HI_SAT : hi_run + 1'b1;
         else          hi_run <= '0;
         if (conv_q && !adc_conv) begin
            hi_at_fall <= hi_run;
            rise_cnt   <= '0;
         end else if (adc_sck && !sck_q) begin
            rise_cnt <= rise_cnt + 1'b1;
         end
      end
   end

   p_idle_conv_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> adc_conv);

   p_sck_conv_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      adc_sck |-> !adc_conv);

   p_conv_time_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(adc_sck) && rise_cnt == '0) |-> (hi_at_fall == HI_SAT));

   p_rise_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(adc_sck) |-> (rise_cnt < RMAX));

   p_rise_total_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(adc_conv) |-> (rise_cnt == '0 || rise_cnt == RMAX));

   p_sdi_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(adc_sdi) |-> ($fell(adc_sck) || $fell(adc_conv)));

   p_valid_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (rise_cnt == RMAX));

   p_valid_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(
   .DATA_W   (DATA_W),
   .CONV_CYC (CONV_CYC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .adc_conv  (adc_conv),
   .adc_sck   (adc_sck),
   .adc_sdi   (adc_sdi),
   .busy      (busy),
   .res_valid (res_valid)
);

// File: tb/sim_adc_seq_ctrl.sv
`timescale 1ns/1ps
module sim_adc_seq_ctrl;
   localparam int CLK_T  = 10;
   localparam int DW     = 16;
   localparam int DVW    = 8;
   localparam int SAMP_C = 4;
   localparam int CONV_C = 64;
   localparam int NV     = 8;

   // {single, odd, ch0, ch1, div, expected data, expected tag}
   localparam logic [59:0] VEC [NV] = '{
      {1'b1, 1'b0, 16'h1234, 16'hABCD, 8'd2, 16'h1234, 2'b10},
      {1'b1, 1'b1, 16'h0000, 16'hFFFF, 8'd4, 16'h0000, 2'b10},
      {1'b0, 1'b0, 16'h8000, 16'h7FFF, 8'd3, 16'h7FFF, 2'b11},
      {1'b0, 1'b1, 16'h9000, 16'h1000, 8'd0, 16'h8000, 2'b00},
      {1'b1, 1'b0, 16'h0100, 16'h0300, 8'd6, 16'h0200, 2'b01},
      {1'b0, 1'b0, 16'h5555, 16'hAAAA, 8'd1, 16'h5555, 2'b10},
      {1'b1, 1'b1, 16'h0010, 16'h0020, 8'd2, 16'h0000, 2'b00},
      {1'b0, 1'b0, 16'hFFFF, 16'h0001, 8'd2, 16'h0001, 2'b11}
   };

   logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, sel_single = 1'b0, sel_odd = 1'b0;
   logic [DVW-1:0] div = 8'd2;
   logic conv, sck, sdi, busy, valid, sdo_m;
   logic [DW-1:0] rdata;
   logic [1:0] rtag;
   int n_chk = 0, n_fail = 0;

   always #(CLK_T/2) clk = ~clk;

   adc_seq_ctrl #(.DATA_W(DW), .DIV_W(DVW), .SAMP_CYC(SAMP_C), .CONV_CYC(CONV_C),
                  .RST_CFG(2'b10)) u0 (
      .clk(clk), .rst_n(rst_n), .start_req(req), .mode_single(sel_single),
      .chan_odd(sel_odd), .sck_div(div), .adc_conv(conv), .adc_sck(sck),
      .adc_sdi(sdi), .adc_sdo(sdo_m), .busy(busy), .res_valid(valid),
      .res_data(rdata), .res_tag(rtag));

   // behavioural converter
   logic [DW-1:0] ch0 = '0, ch1 = '0, m_sh = '0, m_res = '0;
   logic [1:0] m_cur = 2'b10, m_new = 2'b00, sent = 2'b00;
   int m_ncfg = 0, bidx = 0, late_hi = 0, sck_in_conv = 0;
   time t_rise = 0;

   function automatic logic [DW-1:0] code_of(input logic [1:0] c, input logic [DW-1:0] a, b);
      if (c[1]) return c[0] ? b : a;
      if (c[0]) return (b > a) ? b - a : '0;
      return (a > b) ? a - b : '0;
   endfunction

   initial sdo_m = 1'b0;

   always @(posedge conv) begin
      t_rise = $time;
      if (m_ncfg == 2) m_cur = m_new;
      m_res  = code_of(m_cur, ch0, ch1);
      m_ncfg = 0;
   end
   always @(negedge conv) begin
      m_sh  = (($time - t_rise) >= CONV_C * CLK_T) ? m_res : 16'hDEAD;
      sdo_m = m_sh[DW-1];
      bidx  = 0;
   end
   always @(negedge sck) if (!conv) begin
      m_sh  = {m_sh[DW-2:0], 1'b0};
      sdo_m = m_sh[DW-1];
   end
   always @(posedge sck) begin
      if (conv) sck_in_conv++;
      else begin
         if (m_ncfg < 2) begin m_new = {m_new[0], sdi}; m_ncfg++; end
         if (bidx < 2) sent = {sent[0], sdi};
         else if (sdi) late_hi++;
         bidx++;
      end
   end

   // clock-domain monitors
   int chi = 0, last_chi = 0, hcnt = 0, last_hi = 0;
   always @(posedge clk) begin
      if (conv) chi <= chi + 1;
      else begin if (chi != 0) last_chi <= chi; chi <= 0; end
      if (sck) hcnt <= hcnt + 1;
      else if (hcnt != 0) begin last_hi <= hcnt; hcnt <= 0; end
   end

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic pulse_req();
      @(negedge clk) req = 1'b1;
      @(negedge clk) req = 1'b0;
   endtask

   task automatic wait_valid(output int n);
      n = 0;
      while (!valid && n < 5000) begin @(negedge clk); n++; end
   endtask

   function automatic int eff_div(input logic [DVW-1:0] d);
      return (d < 2) ? 2 : int'(d & 8'hFE);
   endfunction

   bit done_flag = 0;
   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finish_run();
   end

   initial begin
      int n, e;
      repeat (3) @(negedge clk);
      // R1 during reset
      chk(conv == 1'b1 && sck == 1'b0 && sdi == 1'b0, "R1 pins in reset", {conv, sck, sdi}, 3'b100);
      chk(busy == 1'b0 && valid == 1'b0, "R1 status in reset", {busy, valid}, 0);
      rst_n = 1'b1;
      repeat (40) @(negedge clk);
      chk(conv == 1'b1 && busy == 1'b0 && sck == 1'b0, "R2 idle holds conv high", {conv, busy, sck}, 3'b100);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         {sel_single, sel_odd, ch0, ch1, div} = VEC[i][59:18];
         e = eff_div(div);
         pulse_req();
         wait_valid(n);
         chk(n == SAMP_C + CONV_C + 16 * e, "R10 latency", n, SAMP_C + CONV_C + 16 * e);
         chk(rdata == VEC[i][17:2], "R6 R9 result", rdata, VEC[i][17:2]);
         chk(rtag == VEC[i][1:0], "R8 tag", rtag, VEC[i][1:0]);
         chk(bidx == DW, "R5 rising edges", bidx, DW);
         chk(sent == {VEC[i][59], VEC[i][58]}, "R7 word order", sent, {VEC[i][59], VEC[i][58]});
         chk(last_chi == CONV_C, "R3 conversion hold", last_chi, CONV_C);
         @(negedge clk);
         chk(valid == 1'b0, "R12 single pulse", valid, 0);
         chk(last_hi == e / 2, "R10 sck high time", last_hi, e / 2);
         chk(conv == 1'b1 && busy == 1'b0, "R2 back to idle", {conv, busy}, 2'b10);
      end
      chk(late_hi == 0, "R7 trailing sdi low", late_hi, 0);
      chk(sck_in_conv == 0, "R4 sck only with conv low", sck_in_conv, 0);

      // R11: second request while busy is queued
      @(negedge clk);
      sel_single = 1'b1; sel_odd = 1'b1; ch0 = 16'h0BBB; ch1 = 16'h0AAA; div = 8'd2;
      pulse_req();
      repeat (10) @(negedge clk);
      chk(busy == 1'b1, "R11 busy during frame", busy, 1);
      pulse_req();
      wait_valid(n);
      chk(rdata == 16'h0111 && rtag == 2'b00, "R11 first result", {rtag, rdata}, {2'b00, 16'h0111});
      @(negedge clk);
      wait_valid(n);
      chk(n == SAMP_C + CONV_C + 32, "R11 queued frame latency", n, SAMP_C + CONV_C + 32);
      chk(rdata == 16'h0AAA && rtag == 2'b11, "R11 queued result", {rtag, rdata}, {2'b11, 16'h0AAA});

      // R1: reset in the middle of a readout
      @(negedge clk);
      pulse_req();
      repeat (SAMP_C + CONV_C + 8) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk(conv == 1'b1 && sck == 1'b0 && valid == 1'b0 && busy == 1'b0,
          "R1 mid-frame reset", {conv, sck, valid, busy}, 4'b1000);
      chk(rtag == 2'b10, "R1 R8 tag reset value", rtag, 2'b10);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      finish_run();
   end
endmodule